// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block sits at the front of an instruction pipeline for a byte-addressed instruction set whose instructions are two, four or six bytes long. Each cycle it may be handed a six-byte window that starts at the first byte of the current instruction, together with that instruction's 24-bit address. It also gets a parallel view of the sixteen general registers. From the leading opcode bits it works out which of five layouts the instruction uses: register pair, indexed storage, storage with immediate, two-byte-opcode storage, or storage to storage. It then pulls out the register fields, the immediate byte and the operand length field.

For the formats that name storage, the block forms each 24-bit operand address from a base register, an optional index register and a 12-bit unsigned displacement. It also produces the address of the following instruction, so a fetch unit can step to the next instruction without decoding it again. All results are captured one clock after the input, and a valid strobe marks them.

Top module: `vlid_decoder`

## Requirements
- R1: The format code comes from opcode byte bits [7:6]: 00 gives register pair (code 0), 01 gives indexed storage (code 1), 11 gives storage to storage (code 4). For 10, an opcode upper nibble of 4'hB gives two-byte-opcode storage (code 3) and any other nibble gives storage-immediate (code 2). The opcode output holds both first bytes for code 3, and otherwise the first byte with a zero low byte.
- R2: The length output is 2 bytes for code 0, 4 bytes for codes 1, 2 and 3, and 6 bytes for code 4.
- R3: The next-address output equals the instruction address plus the length, modulo 2^24.
- R4: For indexed storage, the first register field is byte 1 [7:4] and the index field is byte 1 [3:0]. The base field is byte 2 [7:4] and the displacement is {byte 2 [3:0], byte 3}. The address is base register plus index register plus displacement.
- R5: For storage-immediate, the immediate is byte 1. For storage-immediate and two-byte-opcode storage, the first address is the base register (byte 2 [7:4]) plus the displacement ({byte 2 [3:0], byte 3}).
- R6: For storage to storage, the length field is byte 1. The first address uses base byte 2 [7:4] with displacement {byte 2 [3:0], byte 3}. The second address uses base byte 4 [7:4] with displacement {byte 4 [3:0], byte 5}.
- R7: A base or index field of zero adds zero, whatever register 0 holds.
- R8: Every address sum wraps modulo 2^24.
- R9: Results appear on the clock edge after an accepted input, and the valid strobe is high for exactly those cycles. Reset clears the strobe and every output.
- R10: Outputs that do not belong to the decoded format read zero: the register fields outside formats 0 and 1, the immediate outside format 2, the length field and second address outside format 4, and the first address for format 0.
- R11: Window bytes beyond the decoded length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Window and address are valid this cycle |
| pc_i | input | 24 | Address of the instruction's first byte |
| win_i | input | 48 | Instruction bytes, byte 0 in bits [47:40] |
| gpr_i | input | 384 | Register file view, register k in bits [24k+23:24k] |
| out_valid_o | output | 1 | Decoded results valid |
| out_fmt_o | output | 3 | Format code |
| out_op_o | output | 16 | Opcode (one or two bytes) |
| out_len_o | output | 3 | Instruction length in bytes |
| out_next_pc_o | output | 24 | Address of the following instruction |
| out_r1_o | output | 4 | First register field |
| out_r2_o | output | 4 | Second register or index field |
| out_ea1_o | output | 24 | First operand address |
| out_ea2_o | output | 24 | Second operand address |
| out_imm_o | output | 8 | Immediate byte |
| out_lfield_o | output | 8 | Operand length field |

## Verification
Assertions check four things on every cycle. The strobe tracks the accepted input with one cycle of delay. The length agrees with the format. The next address equals the previous cycle's address plus the length. Fields that do not belong to the format read zero. Only the bench scenarios can show the rest: correct format selection across the opcode space, field positions, the three address-forming rules, register 0 being ignored as a base or index, wrap at the top of the address space, and trailing window bytes having no effect. For each of these the bench computes the expected numbers from register values that it sets itself.

// File: rtl/vlid_pkg.sv
// Package: shared format codes for the variable-length decoder.
// Assumes: every unit of the decoder imports these codes.
package vlid_pkg;
    typedef enum logic [2:0] {
        FMT_RR = 3'd0,
        FMT_RX = 3'd1,
        FMT_SI = 3'd2,
        FMT_ST = 3'd3,
        FMT_SS = 3'd4
    } fmt_e;
endpackage

// File: rtl/vlid_classify.sv
// Module: opcode classifier. Maps the upper opcode nibble to a format
// code and an instruction length in bytes.
// Assumes: only the upper nibble of the first byte decides the layout.
module vlid_classify
    import vlid_pkg::*;
(
    input  logic [3:0] op_hi_i,
    output fmt_e       fmt_o,
    output logic [2:0] nbytes_o
);
    // Pick the format from the top two bits, splitting the 10 group by nibble.
    always_comb begin
        unique case (op_hi_i[3:2])
            2'b00:   fmt_o = FMT_RR;
            2'b01:   fmt_o = FMT_RX;
            2'b10:   fmt_o = (op_hi_i == 4'hB) ? FMT_ST : FMT_SI;
            default: fmt_o = FMT_SS;
        endcase
    end

    // Byte count per format.
    always_comb begin
        unique case (fmt_o)
            FMT_RR:  nbytes_o = 3'd2;
            FMT_SS:  nbytes_o = 3'd6;
            default: nbytes_o = 3'd4;
        endcase
    end
endmodule

// File: rtl/vlid_agen.sv
// Module: operand address unit. Adds base register, optional index
// register and a zero-extended displacement, wrapping at AW bits.
// Assumes: register selector 0 stands for the value zero; AW > DISPW.
module vlid_agen #(
    parameter int AW    = 24,
    parameter int NREG  = 16,
    parameter int DISPW = 12,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic [NREG*AW-1:0] gpr_i,
    input  logic [RIDX-1:0]    base_i,
    input  logic [RIDX-1:0]    index_i,
    input  logic               use_index_i,
    input  logic [DISPW-1:0]   disp_i,
    output logic [AW-1:0]      ea_o
);
    logic [AW-1:0] base_val, index_val;

    // Read the base register, forcing zero for selector 0.
    always_comb base_val = (base_i == '0) ? '0 : gpr_i[base_i*AW +: AW];

    // Read the index register only when the format uses one.
    always_comb index_val = (!use_index_i || index_i == '0) ? '0
                            : gpr_i[index_i*AW +: AW];

    // Three-way sum truncated to the address width.
    always_comb ea_o = base_val + index_val + {{(AW-DISPW){1'b0}}, disp_i};
endmodule

// File: rtl/vlid_decoder.sv
// Module: top of the variable-length instruction decoder. Splits the
// window into bytes, classifies the opcode, forms up to two operand
// addresses and registers all results with a valid strobe.
// Assumes: win_i starts at the instruction's first byte (byte 0 in the
// top bits); gpr_i is stable in the cycle in_valid_i is high.
module vlid_decoder
    import vlid_pkg::*;
#(
    parameter int AW    = 24,
    parameter int NREG  = 16,
    parameter int DISPW = 12,
    parameter int WINB  = 6,
    localparam int RIDX = $clog2(NREG),
    localparam int WINW = 8 * WINB,
    localparam int NOPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [AW-1:0]      pc_i,
    input  logic [WINW-1:0]    win_i,
    input  logic [NREG*AW-1:0] gpr_i,
    output logic               out_valid_o,
    output logic [2:0]         out_fmt_o,
    output logic [15:0]        out_op_o,
    output logic [2:0]         out_len_o,
    output logic [AW-1:0]      out_next_pc_o,
    output logic [RIDX-1:0]    out_r1_o,
    output logic [RIDX-1:0]    out_r2_o,
    output logic [AW-1:0]      out_ea1_o,
    output logic [AW-1:0]      out_ea2_o,
    output logic [7:0]         out_imm_o,
    output logic [7:0]         out_lfield_o
);
    logic [7:0]       byt [WINB];
    fmt_e             fmt;
    logic [2:0]       nbytes;
    logic [AW-1:0]    ea   [NOPS];
    logic [RIDX-1:0]  r1, r2;
    logic [15:0]      opc;

    // Split the window into bytes, byte 0 first.
    for (genvar k = 0; k < WINB; k++) begin : g_bytes
        assign byt[k] = win_i[(WINB-1-k)*8 +: 8];
    end

    vlid_classify u_cls (
        .op_hi_i  (byt[0][7:4]),
        .fmt_o    (fmt),
        .nbytes_o (nbytes)
    );

    // One address unit per storage operand; operand k sits at bytes 2+2k, 3+2k.
    for (genvar k = 0; k < NOPS; k++) begin : g_ops
        vlid_agen #(.AW(AW), .NREG(NREG), .DISPW(DISPW)) u_agen (
            .gpr_i       (gpr_i),
            .base_i      (byt[2+2*k][7:4]),
            .index_i     (byt[1][3:0]),
            .use_index_i ((k == 0) && (fmt == FMT_RX)),
            .disp_i      ({byt[2+2*k][3:0], byt[3+2*k]}),
            .ea_o        (ea[k])
        );
    end

    // Register fields exist only in the register-pair and indexed formats.
    always_comb begin
        r1 = '0;
        r2 = '0;
        if (fmt == FMT_RR || fmt == FMT_RX) begin
            r1 = byt[1][7:4];
            r2 = byt[1][3:0];
        end
    end

    // Opcode is two bytes wide only for the storage format.
    always_comb opc = (fmt == FMT_ST) ? {byt[0], byt[1]} : {byt[0], 8'h00};

    // Output stage: capture decoded results, masking fields the format lacks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o   <= 1'b0;
            out_fmt_o     <= '0;
            out_op_o      <= '0;
            out_len_o     <= '0;
            out_next_pc_o <= '0;
            out_r1_o      <= '0;
            out_r2_o      <= '0;
            out_ea1_o     <= '0;
            out_ea2_o     <= '0;
            out_imm_o     <= '0;
            out_lfield_o  <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_fmt_o     <= fmt;
                out_op_o      <= opc;
                out_len_o     <= nbytes;
                out_next_pc_o <= pc_i + {{(AW-3){1'b0}}, nbytes};
                out_r1_o      <= r1;
                out_r2_o      <= r2;
                out_ea1_o     <= (fmt == FMT_RR) ? '0 : ea[0];
                out_ea2_o     <= (fmt == FMT_SS) ? ea[1] : '0;
                out_imm_o     <= (fmt == FMT_SI) ? byt[1] : 8'h00;
                out_lfield_o  <= (fmt == FMT_SS) ? byt[1] : 8'h00;
            end
        end
    end

    // R9: strobe follows an accepted input by one cycle.
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    // R2: length agrees with the registered format code.
    p_len_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_fmt_o == 3'd0 && out_len_o == 3'd2) ||
                         (out_fmt_o == 3'd4 && out_len_o == 3'd6) ||
                         (out_fmt_o inside {3'd1, 3'd2, 3'd3} && out_len_o == 3'd4)));

    // R3: next address is last cycle's address plus the length.
    p_next_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> out_next_pc_o == AW'($past(pc_i) + {{(AW-3){1'b0}}, out_len_o}));

    // R10: fields foreign to the format stay zero.
    p_ss_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_fmt_o != 3'd4) |-> (out_ea2_o == '0 && out_lfield_o == 8'h00));
    p_imm_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_fmt_o != 3'd2) |-> out_imm_o == 8'h00);
endmodule

// File: tb/tb_vlid_decoder.sv
module tb_vlid_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int NR = 16;

    typedef struct packed {
        logic [2:0]    fmt;
        logic [15:0]   op;
        logic [2:0]    len;
        logic [AW-1:0] npc;
        logic [3:0]    r1;
        logic [3:0]    r2;
        logic [AW-1:0] ea1;
        logic [AW-1:0] ea2;
        logic [7:0]    imm;
        logic [7:0]    lf;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [47:0] win = '0;
    logic [NR*AW-1:0] gpr;
    logic [AW-1:0] regs [NR];

    logic          o_valid;
    logic [2:0]    o_fmt;
    logic [15:0]   o_op;
    logic [2:0]    o_len;
    logic [AW-1:0] o_npc, o_ea1, o_ea2;
    logic [3:0]    o_r1, o_r2;
    logic [7:0]    o_imm, o_lf;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    exp_t q [$];
    string tagq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlid_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .pc_i(pc),
        .win_i(win), .gpr_i(gpr), .out_valid_o(o_valid), .out_fmt_o(o_fmt),
        .out_op_o(o_op), .out_len_o(o_len), .out_next_pc_o(o_npc),
        .out_r1_o(o_r1), .out_r2_o(o_r2), .out_ea1_o(o_ea1), .out_ea2_o(o_ea2),
        .out_imm_o(o_imm), .out_lfield_o(o_lf)
    );

    always_comb for (int i = 0; i < NR; i++) gpr[i*AW +: AW] = regs[i];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] rv(logic [3:0] sel);
        return (sel == 4'd0) ? '0 : regs[sel];
    endfunction

    // Expected results built from the requirement text.
    function automatic exp_t model(logic [AW-1:0] a, logic [47:0] w);
        exp_t e;
        logic [7:0] b0, b1, b2, b3, b4, b5;
        logic [AW-1:0] d1, d2;
        {b0, b1, b2, b3, b4, b5} = w;
        e = '0;
        d1 = {12'h000, b2[3:0], b3};
        d2 = {12'h000, b4[3:0], b5};
        if (b0[7:6] == 2'b00) begin
            e.fmt = 3'd0; e.len = 3'd2; e.r1 = b1[7:4]; e.r2 = b1[3:0];
        end else if (b0[7:6] == 2'b01) begin
            e.fmt = 3'd1; e.len = 3'd4; e.r1 = b1[7:4]; e.r2 = b1[3:0];
            e.ea1 = rv(b2[7:4]) + rv(b1[3:0]) + d1;
        end else if (b0[7:6] == 2'b11) begin
            e.fmt = 3'd4; e.len = 3'd6; e.lf = b1;
            e.ea1 = rv(b2[7:4]) + d1;
            e.ea2 = rv(b4[7:4]) + d2;
        end else if (b0[7:4] == 4'hB) begin
            e.fmt = 3'd3; e.len = 3'd4; e.ea1 = rv(b2[7:4]) + d1;
        end else begin
            e.fmt = 3'd2; e.len = 3'd4; e.imm = b1; e.ea1 = rv(b2[7:4]) + d1;
        end
        e.op = (e.fmt == 3'd3) ? {b0, b1} : {b0, 8'h00};
        e.npc = a + {21'd0, e.len};
        return e;
    endfunction

    // Driver: push expectation, present the instruction for one cycle.
    task automatic send(string tag, logic [AW-1:0] a, logic [47:0] w);
        q.push_back(model(a, w));
        tagq.push_back(tag);
        pc = a;
        win = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each produced result against the queue head.
    always @(negedge clk) begin
        if (rst_n && o_valid) begin
            if (q.size() == 0) begin
                chk("R9", "unexpected_valid", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tagq.pop_front();
                chk({t, "/R1"}, "fmt", o_fmt, e.fmt);
                chk({t, "/R1"}, "op", o_op, e.op);
                chk({t, "/R2"}, "len", o_len, e.len);
                chk({t, "/R3"}, "next_pc", o_npc, e.npc);
                chk({t, "/R10"}, "r1", o_r1, e.r1);
                chk({t, "/R10"}, "r2", o_r2, e.r2);
                chk(t, "ea1", o_ea1, e.ea1);
                chk(t, "ea2", o_ea2, e.ea2);
                chk(t, "imm", o_imm, e.imm);
                chk(t, "lfield", o_lf, e.lf);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) regs[i] = AW'(i * 24'h000010);
        regs[0]  = 24'h111111;
        regs[1]  = 24'h000100;
        regs[2]  = 24'h000020;
        regs[3]  = 24'h123456;
        regs[5]  = 24'h0ABCDE;
        regs[15] = 24'hFFFFF0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "reset_valid", o_valid, 0);
        chk("R9", "reset_ea1", o_ea1, 0);
        chk("R9", "reset_npc", o_npc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send("R1_rr", 24'h001000, 48'h1A35_AAAA_AAAA);
        send("R4_rx", 24'h001002, 48'h5A35_2FFF_CCCC);
        send("R7_zero_regs", 24'h001006, 48'h4140_0010_0000);
        send("R5_si", 24'h00100A, 48'h92C7_3123_7777);
        send("R5_st", 24'h00100E, 48'hB205_1800_9999);
        send("R6_ss", 24'h001012, 48'hD20F_3010_50FF);
        send("R8_wrap", 24'hFFFFFE, 48'h580F_F020_0000);
        send("R8_ss_wrap", 24'hFFFFFC, 48'hC0FF_FFFF_FFFF);
        send("R11_trail_a", 24'h000200, 48'h2C47_0000_0000);
        send("R11_trail_b", 24'h000200, 48'h2C47_FFFF_FFFF);
        send("R1_si_edge", 24'h000300, 48'hAF01_0002_0000);
        // R9: idle cycle gives no strobe
        @(negedge clk);
        chk("R9", "idle_valid", o_valid, 0);
        @(negedge clk);
        chk("R9", "queue_drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule